// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with a small register window. Software arms it with a 10-bit starting value. A single-cycle tick strobe, supplied from outside by a coarse prescaler of about 0.6 s per tick, counts it down. Software proves it is alive by writing the reload word. If it stops doing so, the first expiry only raises an interrupt. The interrupt goes to the management handler (SMI) or to the non-maskable line (NMI), chosen by a routing bit.

If a second expiry follows with no reload in between, the block records this in its status. It then requests a system reset, unless the no-reboot input is high, in which case it only interrupts again. A sticky lock bit guards the routing bit. The window also holds a pair of mailbox bytes that raise status flags when written, plus message, scratch and software-interrupt bytes.

The window is addressed by 16-bit word index with two byte-lane enables. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_word`. There is no back-pressure: every write is accepted in the cycle it is presented.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the initial-value word (index 9) reads 0x0004, control-2 (index 5) reads 0x0008, the software-interrupt word (index 8) reads 0x0003, and control-1 (index 4), the reload word (index 0) and both status words (index 2, 3) read 0. The timer is stopped and the routing bit is 0.
- R2: A write replaces only the byte lanes whose enable is set: lane 0 is bits 7:0 and lane 1 is bits 15:8. Index 1 holds data-in in lane 0 and data-out in lane 1. Index 6 holds the two message bytes. The scratch byte (index 7) and the software-interrupt byte (index 8) occupy lane 0, with lane 1 reading 0.
- R3: The timer may run only when control-1 bit 11 (halt) is 0 and the initial value is greater than 1. The initial-value word keeps only its low 10 bits (write mask 0x03FF).
- R4: A write to index 0 clears the consecutive-timeout record. If the timer may run, the write restarts the count from the initial value. Otherwise the written value is stored and read back from index 0.
- R5: With an initial value N, the N-th tick after a start ends the count. At that point status-1 bit 3 is set and the count restarts from the initial value. One cycle later a one-cycle `smi_pulse` appears if the routing bit is 1, or a one-cycle `nmi_pulse` if it is 0.
- R6: An expiry that follows an earlier expiry, with no write to index 0 between them, sets status-2 bits 1 and 2 and clears the record. If `no_reboot` is 0, only `rst_req_pulse` fires: the timer stops and index 0 reads 0. If `no_reboot` is 1, the interrupt of R5 fires instead.
- R7: Control-1 bit 12 (lock), once set, stays set until reset. While it is set, `route_wr` has no effect on the routing bit.
- R8: Writing lane 0 of index 1 sets status-1 bit 1 and causes one `smi_pulse`. Writing lane 1 of index 1 sets status-1 bit 2 and causes no pulse.
- R9: Writes are masked: status-1 by 0xE870, status-2 by 0xFFF8, control-1 by 0xFEFF. Masked-out bits are written as 0.
- R10: While the timer runs, bits 9:0 of index 0 show the ticks remaining before expiry.
- R11: A write to control-1 restarts the count from the initial value if the timer may run, and stops the timer otherwise.
- R12: While the timer is stopped, ticks change nothing and cause no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count strobe from the prescaler |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_word | input | 4 | 16-bit word index in the window |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_word` |
| route_wr | input | 1 | Request to change the routing bit |
| route_val | input | 1 | New routing bit value (1 = SMI) |
| no_reboot | input | 1 | When high, vetoes the reset request |
| smi_route | output | 1 | Current routing bit |
| smi_pulse | output | 1 | One-cycle management interrupt |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt |
| rst_req_pulse | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the tick strobe, the bus write and the routing request are synchronous and stable across the rising edge. They also assume that `no_reboot` is steady while an expiry is being resolved. The stimulus changes every input on the falling edge and holds `tick_en` for exactly one cycle. It toggles `no_reboot` only while no tick is pending, and it never changes the initial value to 0 or 1 while the count is running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned LANES = REG_W / 8;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    W_RELOAD = 4'd0,
    W_MAIL   = 4'd1,
    W_STS1   = 4'd2,
    W_STS2   = 4'd3,
    W_CTL1   = 4'd4,
    W_CTL2   = 4'd5,
    W_MSG    = 4'd6,
    W_SCR    = 4'd7,
    W_SWIRQ  = 4'd8,
    W_INIT   = 4'd9
  } word_e;

  localparam logic [REG_W-1:0] STS1_KEEP = 16'hE870;
  localparam logic [REG_W-1:0] STS2_KEEP = 16'hFFF8;
  localparam logic [REG_W-1:0] CTL1_KEEP = 16'hFEFF;
  localparam logic [REG_W-1:0] INIT_KEEP = 16'h03FF;
  localparam logic [REG_W-1:0] ALL_KEEP  = 16'hFFFF;

  localparam logic [REG_W-1:0] INIT_RST  = 16'h0004;
  localparam logic [REG_W-1:0] CTL2_RST  = 16'h0008;
  localparam logic [7:0]       SWIRQ_RST = 8'h03;

  localparam int unsigned B_HALT   = 11;
  localparam int unsigned B_LOCK   = 12;
  localparam int unsigned B_DIN    = 1;
  localparam int unsigned B_DOUT   = 2;
  localparam int unsigned B_TMO    = 3;
  localparam int unsigned B_SECOND = 1;
  localparam int unsigned B_BOOT   = 2;

  // Replace the enabled byte lanes of a register, filtered by its write mask.
  function automatic logic [REG_W-1:0] lane_merge(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] new_v,
    input logic [LANES-1:0] be,
    input logic [REG_W-1:0] keep
  );
    logic [REG_W-1:0] r;
    r = old_v;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8] & keep[i*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reload_wr,
  input  logic [REG_W-1:0] reload_wdata,
  input  logic             ctl1_wr,
  input  logic             halt_now,
  input  logic             halt_next,
  input  logic [CNT_W-1:0] init_val,
  input  logic             no_reboot,
  input  logic             route,
  output logic [REG_W-1:0] cnt_view,
  output logic             evt_timeout,
  output logic             evt_second,
  output logic             smi_p,
  output logic             nmi_p,
  output logic             rst_p
);
  localparam int unsigned PAD_W = REG_W - CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] rld_q;
  logic             running_q;
  logic             toc_q;

  logic init_ok, can_run_now, can_run_next;
  assign init_ok      = init_val > CNT_W'(1);
  assign can_run_now  = !halt_now && init_ok;
  assign can_run_next = !halt_next && init_ok;

  // Writes win over a tick arriving in the same cycle.
  assign evt_timeout = running_q && tick_en && !reload_wr && !ctl1_wr && (cnt_q <= CNT_W'(1));
  assign evt_second  = evt_timeout && toc_q;

  assign cnt_view = running_q ? {rld_q[REG_W-1:CNT_W], cnt_q} : rld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rld_q     <= '0;
      running_q <= 1'b0;
      toc_q     <= 1'b0;
      smi_p     <= 1'b0;
      nmi_p     <= 1'b0;
      rst_p     <= 1'b0;
    end else begin
      smi_p <= 1'b0;
      nmi_p <= 1'b0;
      rst_p <= 1'b0;
      if (reload_wr) begin
        toc_q <= 1'b0;
        if (can_run_now) begin
          cnt_q     <= init_val;
          rld_q     <= {{PAD_W{1'b0}}, init_val};
          running_q <= 1'b1;
        end else begin
          rld_q <= reload_wdata;
        end
      end else if (ctl1_wr) begin
        if (can_run_next) begin
          cnt_q     <= init_val;
          rld_q     <= {{PAD_W{1'b0}}, init_val};
          running_q <= 1'b1;
        end else begin
          running_q <= 1'b0;
        end
      end else if (evt_timeout) begin
        toc_q <= !toc_q;
        if (evt_second && !no_reboot) begin
          rst_p     <= 1'b1;
          running_q <= 1'b0;
          rld_q     <= '0;
        end else begin
          smi_p <= route;
          nmi_p <= !route;
          cnt_q <= init_val;
          rld_q <= {{PAD_W{1'b0}}, init_val};
        end
      end else if (running_q && tick_en) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  a_r6_reset_stops_timer: assert property (@(posedge clk) disable iff (!rst_n)
    rst_p |-> !running_q);
  a_r5_one_event_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smi_p, nmi_p, rst_p}));
  a_r4_reload_clears_record: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> !toc_q);
  a_r12_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |=> !(smi_p || nmi_p || rst_p));
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_word,
  input  logic [LANES-1:0] bus_be,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             route_wr,
  input  logic             route_val,
  input  logic             evt_timeout,
  input  logic             evt_second,
  input  logic [REG_W-1:0] cnt_view,
  output logic             reload_wr,
  output logic [REG_W-1:0] reload_wdata,
  output logic             ctl1_wr,
  output logic             halt_now,
  output logic             halt_next,
  output logic [CNT_W-1:0] init_val,
  output logic             route,
  output logic             din_smi_p
);
  logic [REG_W-1:0] sts1_q, sts2_q, ctl1_q, ctl2_q, init_q;
  logic [7:0]       din_q, dout_q, msg1_q, msg2_q, scr_q, swirq_q;
  logic             route_q;

  logic hit_sts1, hit_sts2, hit_ctl2, hit_init, hit_mail, hit_msg, hit_scr, hit_swirq;
  logic din_wr, dout_wr;
  logic [REG_W-1:0] ctl1_next, sts1_next, sts2_next;

  assign reload_wr = bus_wr && (bus_word == W_RELOAD) && (|bus_be);
  assign ctl1_wr   = bus_wr && (bus_word == W_CTL1)   && (|bus_be);
  assign hit_sts1  = bus_wr && (bus_word == W_STS1);
  assign hit_sts2  = bus_wr && (bus_word == W_STS2);
  assign hit_ctl2  = bus_wr && (bus_word == W_CTL2);
  assign hit_init  = bus_wr && (bus_word == W_INIT);
  assign hit_mail  = bus_wr && (bus_word == W_MAIL);
  assign hit_msg   = bus_wr && (bus_word == W_MSG);
  assign hit_scr   = bus_wr && (bus_word == W_SCR);
  assign hit_swirq = bus_wr && (bus_word == W_SWIRQ);
  assign din_wr    = hit_mail && bus_be[0];
  assign dout_wr   = hit_mail && bus_be[1];

  assign reload_wdata = lane_merge(cnt_view, bus_wdata, bus_be, ALL_KEEP);

  // Lock survives any software write once set.
  assign ctl1_next = lane_merge(ctl1_q, bus_wdata, bus_be, CTL1_KEEP)
                   | (ctl1_q & (REG_W'(1) << B_LOCK));
  assign halt_now  = ctl1_q[B_HALT];
  assign halt_next = ctl1_next[B_HALT];
  assign init_val  = init_q[CNT_W-1:0];
  assign route     = route_q;

  always_comb begin
    sts1_next = hit_sts1 ? lane_merge(sts1_q, bus_wdata, bus_be, STS1_KEEP) : sts1_q;
    if (din_wr)      sts1_next[B_DIN]  = 1'b1;
    if (dout_wr)     sts1_next[B_DOUT] = 1'b1;
    if (evt_timeout) sts1_next[B_TMO]  = 1'b1;
    sts2_next = hit_sts2 ? lane_merge(sts2_q, bus_wdata, bus_be, STS2_KEEP) : sts2_q;
    if (evt_second) begin
      sts2_next[B_SECOND] = 1'b1;
      sts2_next[B_BOOT]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts1_q    <= '0;
      sts2_q    <= '0;
      ctl1_q    <= '0;
      ctl2_q    <= CTL2_RST;
      init_q    <= INIT_RST;
      din_q     <= '0;
      dout_q    <= '0;
      msg1_q    <= '0;
      msg2_q    <= '0;
      scr_q     <= '0;
      swirq_q   <= SWIRQ_RST;
      route_q   <= 1'b0;
      din_smi_p <= 1'b0;
    end else begin
      sts1_q    <= sts1_next;
      sts2_q    <= sts2_next;
      din_smi_p <= din_wr;
      if (ctl1_wr)  ctl1_q <= ctl1_next;
      if (hit_ctl2) ctl2_q <= lane_merge(ctl2_q, bus_wdata, bus_be, ALL_KEEP);
      if (hit_init) init_q <= lane_merge(init_q, bus_wdata, bus_be, INIT_KEEP);
      if (din_wr)   din_q  <= bus_wdata[7:0];
      if (dout_wr)  dout_q <= bus_wdata[15:8];
      if (hit_msg && bus_be[0]) msg1_q <= bus_wdata[7:0];
      if (hit_msg && bus_be[1]) msg2_q <= bus_wdata[15:8];
      if (hit_scr && bus_be[0])   scr_q   <= bus_wdata[7:0];
      if (hit_swirq && bus_be[0]) swirq_q <= bus_wdata[7:0];
      if (route_wr && !ctl1_q[B_LOCK]) route_q <= route_val;
    end
  end

  always_comb begin
    unique case (bus_word)
      W_RELOAD: bus_rdata = cnt_view;
      W_MAIL:   bus_rdata = {dout_q, din_q};
      W_STS1:   bus_rdata = sts1_q;
      W_STS2:   bus_rdata = sts2_q;
      W_CTL1:   bus_rdata = ctl1_q;
      W_CTL2:   bus_rdata = ctl2_q;
      W_MSG:    bus_rdata = {msg2_q, msg1_q};
      W_SCR:    bus_rdata = {8'h00, scr_q};
      W_SWIRQ:  bus_rdata = {8'h00, swirq_q};
      W_INIT:   bus_rdata = init_q;
      default:  bus_rdata = '0;
    endcase
  end

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1_q[B_LOCK] |=> ctl1_q[B_LOCK]);
  a_r7_route_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1_q[B_LOCK] |=> $stable(route_q));
  a_r8_dout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dout_wr |=> sts1_q[B_DOUT]);
  a_r5_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |=> sts1_q[B_TMO]);
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_wr,
  input  logic [3:0]  bus_word,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        route_wr,
  input  logic        route_val,
  input  logic        no_reboot,
  output logic        smi_route,
  output logic        smi_pulse,
  output logic        nmi_pulse,
  output logic        rst_req_pulse
);
  logic             reload_wr, ctl1_wr, halt_now, halt_next, route;
  logic [REG_W-1:0] reload_wdata, cnt_view;
  logic [CNT_W-1:0] init_val;
  logic             evt_timeout, evt_second;
  logic             tmr_smi, din_smi;

  wdt_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_word     (bus_word),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .route_wr     (route_wr),
    .route_val    (route_val),
    .evt_timeout  (evt_timeout),
    .evt_second   (evt_second),
    .cnt_view     (cnt_view),
    .reload_wr    (reload_wr),
    .reload_wdata (reload_wdata),
    .ctl1_wr      (ctl1_wr),
    .halt_now     (halt_now),
    .halt_next    (halt_next),
    .init_val     (init_val),
    .route        (route),
    .din_smi_p    (din_smi)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .reload_wr    (reload_wr),
    .reload_wdata (reload_wdata),
    .ctl1_wr      (ctl1_wr),
    .halt_now     (halt_now),
    .halt_next    (halt_next),
    .init_val     (init_val),
    .no_reboot    (no_reboot),
    .route        (route),
    .cnt_view     (cnt_view),
    .evt_timeout  (evt_timeout),
    .evt_second   (evt_second),
    .smi_p        (tmr_smi),
    .nmi_p        (nmi_pulse),
    .rst_p        (rst_req_pulse)
  );

  assign smi_pulse = tmr_smi | din_smi;
  assign smi_route = route;
endmodule

// File: tb/sim_wdog_twostage.sv
module sim_wdog_twostage;
  localparam int CLK_PERIOD = 10;
  localparam int EV_SMI = 1;
  localparam int EV_NMI = 2;
  localparam int EV_RST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_word = '0;
  logic [1:0] bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic route_wr = 1'b0;
  logic route_val = 1'b0;
  logic no_reboot = 1'b0;
  logic smi_route, smi_pulse, nmi_pulse, rst_req_pulse;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_twostage u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_word(bus_word), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .route_wr(route_wr), .route_val(route_val), .no_reboot(no_reboot),
    .smi_route(smi_route), .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse),
    .rst_req_pulse(rst_req_pulse)
  );

  task automatic expect_ev(input int code, input string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  task automatic seen_ev(input int code);
    vectors++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R12 unexpected pulse: actual %0d expected none", code);
    end else begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != code) begin
        fails++;
        $display("FAIL %s pulse: actual %0d expected %0d", t, code, e);
      end
    end
  endtask

  // Monitor: compares observed pulses against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (smi_pulse)     seen_ev(EV_SMI);
      if (nmi_pulse)     seen_ev(EV_NMI);
      if (rst_req_pulse) seen_ev(EV_RST);
    end
  end

  task automatic wr(input logic [3:0] w, input logic [1:0] be, input logic [15:0] d);
    bus_word = w; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd_chk(input logic [3:0] w, input logic [15:0] exp, input string tag);
    bus_word = w;
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s word %0d: actual %h expected %h", tag, w, bus_rdata, exp);
    end
  endtask

  task automatic bit_chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(posedge clk); @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic set_route(input logic v);
    route_val = v; route_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    route_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd_chk(4'd9, 16'h0004, "R1");
    rd_chk(4'd5, 16'h0008, "R1");
    rd_chk(4'd8, 16'h0003, "R1");
    rd_chk(4'd4, 16'h0000, "R1");
    rd_chk(4'd0, 16'h0000, "R1");
    rd_chk(4'd2, 16'h0000, "R1");
    bit_chk(smi_route, 1'b0, "R1 route");
    // R11 start via control-1, R10 remaining ticks
    wr(4'd4, 2'b11, 16'h0000);
    rd_chk(4'd0, 16'h0004, "R10");
    ticks(1);
    rd_chk(4'd0, 16'h0003, "R10");
    // R5 first expiry with route 0 -> NMI
    ticks(2);
    expect_ev(EV_NMI, "R5");
    ticks(1);
    rd_chk(4'd2, 16'h0008, "R5");
    rd_chk(4'd0, 16'h0004, "R5 reload");
    // R4 reload clears record; route 1 -> SMI
    set_route(1'b1);
    bit_chk(smi_route, 1'b1, "R7 route before lock");
    wr(4'd0, 2'b11, 16'h0000);
    ticks(3);
    expect_ev(EV_SMI, "R4");
    ticks(1);
    rd_chk(4'd3, 16'h0000, "R4");
    // R6 second expiry with no_reboot high -> flags + SMI
    no_reboot = 1'b1;
    ticks(3);
    expect_ev(EV_SMI, "R6");
    ticks(1);
    rd_chk(4'd3, 16'h0006, "R6");
    // R6 record cleared: next is a first expiry again, then reset
    ticks(3);
    expect_ev(EV_SMI, "R6");
    ticks(1);
    no_reboot = 1'b0;
    ticks(3);
    expect_ev(EV_RST, "R6");
    ticks(1);
    rd_chk(4'd0, 16'h0000, "R6 stopped");
    // R12 stopped: ticks do nothing
    ticks(5);
    rd_chk(4'd0, 16'h0000, "R12");
    // R3 initial value 1 does not start; R4 value stored
    wr(4'd9, 2'b11, 16'h0001);
    wr(4'd4, 2'b11, 16'h0000);
    wr(4'd0, 2'b11, 16'h1234);
    rd_chk(4'd0, 16'h1234, "R4");
    ticks(3);
    rd_chk(4'd0, 16'h1234, "R3");
    wr(4'd9, 2'b11, 16'hFFFF);
    rd_chk(4'd9, 16'h03FF, "R3");
    // R11 halt stops, clear restarts
    wr(4'd9, 2'b11, 16'h0005);
    wr(4'd4, 2'b11, 16'h0800);
    ticks(6);
    rd_chk(4'd4, 16'h0800, "R11");
    rd_chk(4'd0, 16'h1234, "R11");
    wr(4'd4, 2'b11, 16'h0000);
    rd_chk(4'd0, 16'h0005, "R11");
    wr(4'd4, 2'b11, 16'h0800);
    ticks(6);
    // R9 masks
    wr(4'd2, 2'b11, 16'hFFFF);
    rd_chk(4'd2, 16'hE870, "R9");
    wr(4'd3, 2'b11, 16'hFFFF);
    rd_chk(4'd3, 16'hFFF8, "R9");
    wr(4'd4, 2'b11, 16'hFFFF);
    rd_chk(4'd4, 16'hFEFF, "R9");
    // R7 lock sticky, route frozen
    wr(4'd4, 2'b11, 16'h0000);
    rd_chk(4'd4, 16'h1000, "R7");
    set_route(1'b0);
    bit_chk(smi_route, 1'b1, "R7 route frozen");
    ticks(4);
    expect_ev(EV_SMI, "R7");
    ticks(1);
    wr(4'd4, 2'b11, 16'h0800);
    rd_chk(4'd4, 16'h1800, "R7");
    // R8 mailboxes
    wr(4'd2, 2'b11, 16'h0000);
    rd_chk(4'd2, 16'h0000, "R9");
    expect_ev(EV_SMI, "R8");
    wr(4'd1, 2'b01, 16'h00A5);
    rd_chk(4'd2, 16'h0002, "R8");
    wr(4'd1, 2'b10, 16'h5A00);
    rd_chk(4'd2, 16'h0006, "R8");
    rd_chk(4'd1, 16'h5AA5, "R2");
    // R2 byte lanes
    wr(4'd6, 2'b11, 16'hBEEF);
    rd_chk(4'd6, 16'hBEEF, "R2");
    wr(4'd7, 2'b11, 16'h1234);
    rd_chk(4'd7, 16'h0034, "R2");
    wr(4'd5, 2'b10, 16'hAB00);
    rd_chk(4'd5, 16'hAB08, "R2");
    repeat (3) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 missing pulses: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule